// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer with Standby Release

An 8-bit up-counter that serves as a watchdog or as an interval timer. Software reaches it through a 16-bit write bus. Each of the two registers opens only when the upper byte of the write carries that register's own key. The counter advances on one of eight prescaler taps of the block clock. An overflow either asks for a reset or raises a held interval interrupt.

The block also times the oscillator settling delay on the way out of standby. A standby request parks the block with the counter frozen. A level change on the wake input starts the count. The following overflow asks the clock source to restart and leaves the overflow flag alone. Counting then continues from zero. If the standby-enable control is still high when the count reaches the half mark 0x80, the block sends the chip back into standby. If software clears that control first, the counter stops and normal operation resumes.

Top module: `wdt_standby_wake`

## Requirements
- R1: A write with `wr_sel_i`=0 and upper byte 0x5A loads the lower byte into the counter. A counter write whose upper byte is anything else leaves the counter unchanged.
- R2: A write with `wr_sel_i`=1 and upper byte 0xA5 updates the control/status register, whose fields are: bit 7 enable, bit 6 interval mode, bit 5 overflow flag, bits 4:3 reading 0, bits 2:0 clock select. Writing 0 to bit 5 clears the flag and writing 1 leaves it as it was. A control write with any other key has no effect.
- R3: After reset the counter and the control/status register read 0x00, and every event output is low.
- R4: Clock select values 0..7 advance the counter once every 2, 4, 8, 16, 32, 64, 256 and 4096 clocks. The prescaler restarts on every accepted write, so after a counter write at edge E with select s, the counter holds start + floor(N/div) at edge E+N.
- R5: In watchdog mode (bit 6=0) with the enable bit set, a wrap from 0xFF to 0x00 sets the flag and drives `rst_req_o` for exactly one cycle, at the edge where the counter shows 0x00.
- R6: In interval mode (bit 6=1) the same wrap sets the flag and raises `itv_irq_o` without a reset request. `itv_irq_o` stays high until software clears the flag.
- R7: With the enable bit clear and no standby sequence active, the counter holds its value.
- R8: A `stby_req_i` pulse moves the block into standby (`standby_o`=1). The counter then stays frozen until `wake_i` changes level.
- R9: After a wake, the counter runs at the selected rate whatever the enable bit holds. Its wrap drives `clk_restart_o` for one cycle, leaves the flag at 0 and drops `standby_o`, and counting continues from 0x00.
- R10: If `stby_en_i` is high when the counter steps to 0x80 after a wake, `stby_reenter_o` pulses for one cycle at that edge. The block then re-enters standby with the counter held at 0x80.
- R11: If `stby_en_i` is low after a wake, the counter stops and the block returns to normal operation with no re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 = counter, 1 = control/status |
| wr_data_i | input | 16 | Key in [15:8], data in [7:0] |
| stby_req_i | input | 1 | Standby entry request |
| stby_en_i | input | 1 | Standby-enable control bit |
| wake_i | input | 1 | Wake event level (NMI or external IRQ) |
| cnt_o | output | 8 | Counter value |
| csr_o | output | 8 | Control/status register value |
| standby_o | output | 1 | Block is in standby (clock stopped) |
| clk_restart_o | output | 1 | One-cycle clock restart request |
| ovf_flag_o | output | 1 | Overflow flag |
| itv_irq_o | output | 1 | Interval interrupt |
| rst_req_o | output | 1 | One-cycle reset request |
| stby_reenter_o | output | 1 | One-cycle request to re-enter standby |

## Verification
A wrong prescaler tap or a mis-gated run condition shows at `cnt_o` within one tick period of the selected divider. It is caught by sampling the counter a known number of edges after a keyed load. A standby sequencer stuck in the wrong state shows up either as a missing `clk_restart_o` at the exact wrap edge or as a counter that moves while `standby_o` is high. A key comparison that is too loose changes `cnt_o` or `csr_o` on the edge right after a bad-key write. A flag set during the wake wrap shows on `ovf_flag_o` in the same cycle as the restart pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_WAKE, ST_POST} wdt_st_e;

  localparam int unsigned CSR_TME = 7;
  localparam int unsigned CSR_ITV = 6;
  localparam int unsigned CSR_OVF = 5;

  // prescaler exponent per clock-select code
  function automatic int unsigned tap_exp(int unsigned idx);
    case (idx)
      0: tap_exp = 1;
      1: tap_exp = 2;
      2: tap_exp = 3;
      3: tap_exp = 4;
      4: tap_exp = 5;
      5: tap_exp = 6;
      6: tap_exp = 8;
      default: tap_exp = 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_W = 12,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NTAP = 1 << SEL_W;

  logic [PRE_W-1:0] div_q;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int unsigned E = wdt_pkg::tap_exp(g);
    assign tap_hit[g] = &div_q[E-1:0];
    initial begin
      AST_TAP_FITS: assert (E <= PRE_W && E >= 1); // R4
    end
  end

  assign tick_o = tap_hit[sel_i];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W/2-1:0] KEY_CNT = 8'h5A,
  parameter logic [DATA_W/2-1:0] KEY_CSR = 8'hA5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                cnt_step_i,
  input  logic                set_flag_i,
  output logic [DATA_W/2-1:0] cnt_o,
  output logic [DATA_W/2-1:0] csr_o,
  output logic                cnt_wr_o,
  output logic                csr_wr_o
);
  localparam int unsigned HW = DATA_W / 2;

  logic [HW-1:0] key, low;
  logic [HW-1:0] cnt_q, csr_q;

  assign key = wr_data_i[DATA_W-1:HW];
  assign low = wr_data_i[HW-1:0];
  assign cnt_wr_o = wr_en_i && !wr_sel_i && (key == KEY_CNT);
  assign csr_wr_o = wr_en_i &&  wr_sel_i && (key == KEY_CSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (cnt_wr_o)   cnt_q <= low;
    else if (cnt_step_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= '0;
    else begin
      if (csr_wr_o) begin
        csr_q[CSR_TME] <= low[CSR_TME];
        csr_q[CSR_ITV] <= low[CSR_ITV];
        csr_q[2:0]     <= low[2:0];
      end
      csr_q[4:3] <= '0;
      // set wins over a clearing write in the same cycle
      if (set_flag_i)                     csr_q[CSR_OVF] <= 1'b1;
      else if (csr_wr_o && !low[CSR_OVF]) csr_q[CSR_OVF] <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign csr_o = csr_q;

  AST_CNT_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr_o && !cnt_step_i) |=> $stable(cnt_q)); // R1
  AST_CSR_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_wr_o && !set_flag_i) |=> $stable(csr_q)); // R2
endmodule

// File: rtl/wdt_standby_fsm.sv
module wdt_standby_fsm
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_req_i,
  input  logic             stby_en_i,
  input  logic             wake_i,
  input  logic             tme_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             cnt_step_o,
  output logic             pre_clr_o,
  output logic             in_run_o,
  output logic             standby_o,
  output logic             restart_o,
  output logic             reenter_o
);
  localparam logic [CNT_W-1:0] HALF    = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

  wdt_st_e st_q;
  logic    wake_q, restart_q, reenter_q, run, wake_edge;

  assign wake_edge  = wake_i != wake_q;
  assign run        = (st_q == ST_RUN && tme_i) || (st_q == ST_WAKE) ||
                      (st_q == ST_POST && stby_en_i);
  assign cnt_step_o = run && tick_i;
  assign pre_clr_o  = (st_q == ST_WAIT) && wake_edge;
  assign in_run_o   = st_q == ST_RUN;
  assign standby_o  = (st_q == ST_WAIT) || (st_q == ST_WAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      wake_q    <= 1'b0;
      restart_q <= 1'b0;
      reenter_q <= 1'b0;
    end else begin
      wake_q    <= wake_i;
      restart_q <= 1'b0;
      reenter_q <= 1'b0;
      case (st_q)
        ST_RUN:  if (stby_req_i) st_q <= ST_WAIT;
        ST_WAIT: if (wake_edge) st_q <= ST_WAKE;
        ST_WAKE: if (cnt_step_o && (&cnt_i)) begin
          st_q      <= ST_POST;
          restart_q <= 1'b1;
        end
        ST_POST: begin
          if (!stby_en_i) st_q <= ST_RUN;
          else if (cnt_step_o && cnt_i == HALF_M1) begin
            st_q      <= ST_WAIT;
            reenter_q <= 1'b1;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign restart_o = restart_q;
  assign reenter_o = reenter_q;

  AST_REENTER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reenter_q |-> (cnt_i == HALF && standby_o)); // R10
  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q); // R9
endmodule

// File: rtl/wdt_standby_wake.sv
module wdt_standby_wake
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 12,
  parameter logic [DATA_W/2-1:0] KEY_CNT = 8'h5A,
  parameter logic [DATA_W/2-1:0] KEY_CSR = 8'hA5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                stby_req_i,
  input  logic                stby_en_i,
  input  logic                wake_i,
  output logic [DATA_W/2-1:0] cnt_o,
  output logic [DATA_W/2-1:0] csr_o,
  output logic                standby_o,
  output logic                clk_restart_o,
  output logic                ovf_flag_o,
  output logic                itv_irq_o,
  output logic                rst_req_o,
  output logic                stby_reenter_o
);
  localparam int unsigned CNT_W = DATA_W / 2;

  logic             tick, step, pre_clr, in_run, set_flag;
  logic             cnt_wr, csr_wr, rst_req_q;
  logic [CNT_W-1:0] cnt, csr;

  wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(3)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_wr | csr_wr | pre_clr),
    .sel_i  (csr[2:0]),
    .tick_o (tick)
  );

  wdt_regs #(.DATA_W(DATA_W), .KEY_CNT(KEY_CNT), .KEY_CSR(KEY_CSR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .cnt_step_i (step),
    .set_flag_i (set_flag),
    .cnt_o      (cnt),
    .csr_o      (csr),
    .cnt_wr_o   (cnt_wr),
    .csr_wr_o   (csr_wr)
  );

  wdt_standby_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_req_i (stby_req_i),
    .stby_en_i  (stby_en_i),
    .wake_i     (wake_i),
    .tme_i      (csr[CSR_TME]),
    .tick_i     (tick),
    .cnt_i      (cnt),
    .cnt_step_o (step),
    .pre_clr_o  (pre_clr),
    .in_run_o   (in_run),
    .standby_o  (standby_o),
    .restart_o  (clk_restart_o),
    .reenter_o  (stby_reenter_o)
  );

  // only a normal-mode wrap touches the flag
  assign set_flag = in_run && step && (&cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= set_flag && !csr[CSR_ITV];
  end

  assign cnt_o      = cnt;
  assign csr_o      = csr;
  assign ovf_flag_o = csr[CSR_OVF];
  assign itv_irq_o  = csr[CSR_OVF] && csr[CSR_ITV];
  assign rst_req_o  = rst_req_q;

  AST_NO_FLAG_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_restart_o |-> !$rose(ovf_flag_o)); // R9
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R5
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (itv_irq_o && !(wr_en_i && wr_sel_i)) |=> itv_irq_o); // R6
  AST_RST_NEEDS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (cnt_o == '0 && ovf_flag_o)); // R5
endmodule

// File: tb/tb_wdt_standby_wake.sv
module tb_wdt_standby_wake;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        stby_req = 1'b0, stby_en = 1'b0, wake = 1'b0;
  logic [7:0]  cnt, csr;
  logic        standby, restart, ovf, irq, rst_req, reenter;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk; // 250 MHz

  wdt_standby_wake dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .stby_req_i(stby_req), .stby_en_i(stby_en),
    .wake_i(wake), .cnt_o(cnt), .csr_o(csr), .standby_o(standby),
    .clk_restart_o(restart), .ovf_flag_o(ovf), .itv_irq_o(irq),
    .rst_req_o(rst_req), .stby_reenter_o(reenter)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [7:0]  start;
    logic [15:0] cycles;
    logic [7:0]  exp;
  } vec_t;

  // R4: expected = start + floor(cycles / divider)
  localparam vec_t VECS [8] = '{
    '{3'd0, 8'h10, 16'd20,   8'h1A},
    '{3'd1, 8'h00, 16'd17,   8'h04},
    '{3'd2, 8'h20, 16'd40,   8'h25},
    '{3'd3, 8'h00, 16'd64,   8'h04},
    '{3'd4, 8'h40, 16'd100,  8'h43},
    '{3'd5, 8'h00, 16'd200,  8'h03},
    '{3'd6, 8'h07, 16'd600,  8'h09},
    '{3'd7, 8'h00, 16'd8192, 8'h02}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 cnt", cnt, 8'h00);
    chk("R3 csr", csr, 8'h00);
    chk("R3 events", {standby, restart, ovf, irq, rst_req, reenter}, 0);

    // R4 table walk
    foreach (VECS[i]) begin
      wr(1'b1, {8'hA5, 5'b10000, VECS[i].sel});
      wr(1'b0, {8'h5A, VECS[i].start});
      repeat (int'(VECS[i].cycles)) @(negedge clk);
      chk($sformatf("R4 sel %0d", VECS[i].sel), cnt, VECS[i].exp);
    end

    // R7 stop, R1/R2 keys
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5A33);
    repeat (20) @(negedge clk);
    chk("R7 hold", cnt, 8'h33);
    wr(1'b0, 16'h1244);
    chk("R1 bad key", cnt, 8'h33);
    wr(1'b0, 16'hA544);
    chk("R1 csr key on cnt", cnt, 8'h33);
    wr(1'b1, 16'h5A87);
    chk("R2 bad key", csr, 8'h00);
    wr(1'b1, 16'hA51F);
    chk("R2 reserved", csr, 8'h07);

    // R5 watchdog wrap
    wr(1'b1, 16'hA580);
    wr(1'b0, 16'h5AFE);
    repeat (3) @(negedge clk);
    chk("R5 before wrap", {rst_req, ovf}, 0);
    @(negedge clk);
    chk("R5 cnt", cnt, 8'h00);
    chk("R5 rst_req", rst_req, 1);
    chk("R5 csr", csr, 8'hA0);
    @(negedge clk);
    chk("R5 pulse", rst_req, 0);
    wr(1'b1, 16'hA500);
    chk("R2 clear flag", ovf, 0);

    // R6 interval
    wr(1'b1, 16'hA5C0);
    wr(1'b0, 16'h5AFE);
    repeat (4) @(negedge clk);
    chk("R6 irq", irq, 1);
    chk("R6 no rst", rst_req, 0);
    repeat (10) @(negedge clk);
    chk("R6 held", irq, 1);
    wr(1'b1, 16'hA5E0);
    chk("R2 write 1 keeps flag", irq, 1);
    wr(1'b1, 16'hA5C0);
    chk("R6 cleared", irq, 0);

    // R8 standby entry
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5AF0);
    stby_en = 1'b1;
    @(negedge clk); stby_req = 1'b1;
    @(negedge clk); stby_req = 1'b0;
    chk("R8 standby", standby, 1);
    repeat (10) @(negedge clk);
    chk("R8 frozen", cnt, 8'hF0);

    // R9 wake wrap
    wake = ~wake;
    repeat (32) @(negedge clk);
    chk("R9 not yet", {restart, cnt}, 9'h0FF);
    @(negedge clk);
    chk("R9 restart", restart, 1);
    chk("R9 cnt", cnt, 8'h00);
    chk("R9 no flag", ovf, 0);
    chk("R9 awake", standby, 0);
    @(negedge clk);
    chk("R9 pulse", restart, 0);

    // R10 re-entry at half mark
    repeat (255) @(negedge clk);
    chk("R10 reenter", reenter, 1);
    chk("R10 cnt", cnt, 8'h80);
    chk("R10 standby", standby, 1);
    repeat (5) @(negedge clk);
    chk("R10 held", {reenter, cnt}, 9'h080);

    // R11 cleared enable stops counter
    wake = ~wake;
    repeat (257) @(negedge clk);
    chk("R11 restart", {restart, cnt}, 9'h100);
    stby_en = 1'b0;
    repeat (600) @(negedge clk);
    chk("R11 stopped", cnt, 8'h00);
    chk("R11 normal", {standby, reenter, ovf}, 0);

    finish_run();
  end
endmodule